// File: doc/BRIEF.md
# Two-Stage Indirect Effective-Address Resolver

This block turns an instruction's address field and its six-bit modification field into a final effective address. The field carries two modification codes. The first code is applied to the base address, and the second code is then applied to that result. A code either keeps the address as it is, adds one of six signed index registers, or performs an indirection. An indirection fetches the word stored at the current address and resolves that word's own address and modification field, using the same rules. Indirection can nest to any depth. The block keeps second codes that are still waiting on a small stack while an inner chain is being resolved.

A sequencer pulses `start` with the base address and the modification field. The index registers are held steady on their port. The block reads memory through a synchronous port with one cycle of latency. When the address is final, or when a fault ends the walk, the block raises `done` for one cycle. The address, the number of indirections and the fault flags stay on the outputs until the next start. The bench uses the indirection count to charge one extra time unit for each indirection.

Top module: `ea_resolver`

## Requirements
- R1: After reset, `done` and `memRdEn` are low, all four error flags are low and `indirCount` is zero.
- R2: `idxField[5:3]` holds the first code and `idxField[2:0]` holds the second code. Code 0 leaves the address unchanged. Code k (1..6) adds index register k, which sits at `idxRegs[13k-1 -: 13]`. Addresses and registers are sign-magnitude: bit 12 is the sign and bits 11:0 are the magnitude. A zero result is reported with the sign clear.
- R3: Code 7 asserts `memRdEn` for exactly one cycle, with `memRdAddr` set to the magnitude of the current address. `memRdData` must be valid in the following cycle. In the fetched word, bit 30 is the address sign, bits 29:18 are the address magnitude and bits 17:12 are the modification field (same code layout as R2). The word's address then replaces the current address, and its two codes are resolved before any code still waiting in the outer chain.
- R4: `indirCount` reports the number of words fetched since the last start.
- R5: Indirection nests. With word(1000) = 1000 with codes 1:7, word(1001) = 1000 with codes 0:2, register 1 = 1 and register 2 = 2, resolving base 1000 with codes 7:2 gives 1004.
- R6: If any intermediate or final sum has a magnitude above 4095, the walk stops and `errOverflow` is set.
- R7: A fetched word whose two codes are both 7 sets `errIllegal` and ends the walk. Codes 7:7 in the start field are legal.
- R8: When the first code is 7, a nonzero second code is saved on an 8-entry stack. A second code of 7 is followed as a tail step without saving. A save attempted while 8 entries are held sets `errStack`.
- R9: An indirection attempted after 64 fetches sets `errLimit` instead of reading.
- R10: Timing is counted from the clock edge that samples `start`. Each code 0..6 applied takes one cycle and each fetch takes two cycles. A zero second code after an indirect first code takes no cycle. A stopping fault takes one cycle (a fetch that returns an illegal word counts as its two fetch cycles). `done` is high in the cycle after the last of these cycles, and for that one cycle only.
- R11: `start` is ignored while a walk is in progress. After `done`, the outputs hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a resolution (sampled only when idle) |
| baseAddr | input | 13 | Sign-magnitude base address |
| idxField | input | 6 | First code in bits 5:3, second code in bits 2:0 |
| idxRegs | input | 78 | Six sign-magnitude index registers, register k in bits 13k-1 down to 13k-13 |
| memRdEn | output | 1 | Memory read strobe |
| memRdAddr | output | 12 | Memory read address |
| memRdData | input | 31 | Word returned one cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| effAddr | output | 13 | Sign-magnitude resolved address |
| indirCount | output | 7 | Number of indirections performed |
| errOverflow | output | 1 | An address left the representable range |
| errIllegal | output | 1 | A fetched word carried codes 7:7 |
| errStack | output | 1 | The pending-code stack was full |
| errLimit | output | 1 | The indirection limit was reached |

## Verification
Plain index arithmetic with mixed-sign registers shows that the code order and the sign-magnitude conversion are right, before any memory access happens. Several chains are then compared against each other: the nested worked case, an index-then-indirect table lookup, a pending zero code, a top-level 7:7 pair and an indirection through a negative address. Together they separate a tail step from a saved code, show that a zero code is skipped, and check that the read address is a magnitude. Self-referencing words that build up saved codes or loop with tail steps drive the stack fault and the limit fault. A start pulse in the middle of a walk shows that the walk in progress is left alone.

// File: rtl/ea_resolve_pkg.sv
package ea_resolve_pkg;

  localparam int CodeW = 3;
  localparam logic [CodeW-1:0] CodeIndirect = 3'd7;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadStart;
    logic doAdd;
    logic push;
    logic pop;
    logic takeWord;
    logic issueRead;
  } eaStrobe_t;

  typedef enum logic [2:0] {
    StIdle,
    StApply1,
    StApply2,
    StWait,
    StDone
  } eaState_t;

endpackage

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_resolve_pkg::*;
#(
  parameter int ByteW      = 6,
  parameter int StackDepth = 8,
  parameter int MaxIndir   = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  eaStrobe_t                 ctl,
  input  logic                      useSecond,
  input  logic [2*ByteW:0]          baseAddr,
  input  logic [2*CodeW-1:0]        idxField,
  input  logic [6*(2*ByteW+1)-1:0]  idxRegs,
  input  logic [5*ByteW:0]          memRdData,
  output logic [2*ByteW-1:0]        memRdAddr,
  output logic [2*ByteW:0]          effAddr,
  output logic [$clog2(MaxIndir+1)-1:0] indirCount,
  output logic [CodeW-1:0]          code1,
  output logic [CodeW-1:0]          code2,
  output logic                      stkEmpty,
  output logic                      stkFull,
  output logic                      cntAtMax,
  output logic                      sumOvf,
  output logic                      wordIllegal
);

  localparam int MagW    = 2 * ByteW;
  localparam int AddrW   = MagW + 1;
  localparam int AccW    = MagW + 2;
  localparam int WordW   = 1 + 5 * ByteW;
  localparam int NumIdx  = 6;
  localparam int CntW    = $clog2(MaxIndir + 1);
  localparam int StkCntW = $clog2(StackDepth + 1);
  localparam int StkIdxW = $clog2(StackDepth);
  localparam int FieldLo = WordW - 1 - AddrW - 2 * CodeW;

  function automatic logic signed [AccW-1:0] smToTc(input logic [AddrW-1:0] v);
    logic signed [AccW-1:0] m;
    m = $signed({2'b00, v[MagW-1:0]});
    return v[MagW] ? -m : m;
  endfunction

  function automatic logic [AccW-1:0] tcMag(input logic signed [AccW-1:0] v);
    return v[AccW-1] ? AccW'(-v) : AccW'(v);
  endfunction

  logic signed [AccW-1:0] acc;
  logic signed [AccW-1:0] sum;
  logic [AccW-1:0]        sumMag;
  logic [AccW-1:0]        accMag;
  logic signed [AccW-1:0] regTc [8];
  logic [CodeW-1:0]       selCode;
  logic [CodeW-1:0]       code1Q, code2Q;
  logic [CodeW-1:0]       stk [StackDepth];
  logic [StkCntW-1:0]     stkCnt;
  logic [StkIdxW-1:0]     stkTop, stkPush;
  logic [CntW-1:0]        indCnt;
  logic [AddrW-1:0]       wordSm;
  logic [2*CodeW-1:0]     wordField;
  logic [CodeW-1:0]       wordC1, wordC2;
  logic                   unusedWordLow;
  logic                   unusedAccTop;

  // index registers converted once, slot 0 and slot 7 add nothing
  assign regTc[0] = '0;
  assign regTc[7] = '0;
  for (genvar g = 1; g <= NumIdx; g++) begin : g_idx
    assign regTc[g] = smToTc(idxRegs[g*AddrW-1 -: AddrW]);
  end

  // single shared adder, operand picked by the phase
  assign selCode = useSecond ? code2Q : code1Q;
  assign sum     = acc + regTc[selCode];
  assign sumMag  = tcMag(sum);
  assign sumOvf  = |sumMag[AccW-1:MagW];

  assign accMag       = tcMag(acc);
  assign unusedAccTop = |accMag[AccW-1:MagW];
  assign memRdAddr    = accMag[MagW-1:0];
  assign effAddr      = {acc[AccW-1], accMag[MagW-1:0]};

  // fetched word: sign and two bytes of address, then the code byte
  assign wordSm        = memRdData[WordW-1 -: AddrW];
  assign wordField     = memRdData[WordW-1-AddrW -: 2*CodeW];
  assign unusedWordLow = ^memRdData[FieldLo-1:0];
  assign wordC1        = wordField[2*CodeW-1:CodeW];
  assign wordC2        = wordField[CodeW-1:0];
  assign wordIllegal   = (wordC1 == CodeIndirect) && (wordC2 == CodeIndirect);

  assign stkTop   = StkIdxW'(stkCnt - 1'b1);
  assign stkPush  = StkIdxW'(stkCnt);
  assign stkEmpty = (stkCnt == '0);
  assign stkFull  = (stkCnt == StkCntW'(StackDepth));
  assign cntAtMax = (indCnt == CntW'(MaxIndir));

  assign code1      = code1Q;
  assign code2      = code2Q;
  assign indirCount = indCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      code1Q <= '0;
      code2Q <= '0;
      stkCnt <= '0;
      indCnt <= '0;
    end else if (ctl.loadStart) begin
      acc    <= smToTc(baseAddr);
      code1Q <= idxField[2*CodeW-1:CodeW];
      code2Q <= idxField[CodeW-1:0];
      stkCnt <= '0;
      indCnt <= '0;
    end else if (ctl.takeWord) begin
      acc    <= smToTc(wordSm);
      code1Q <= wordC1;
      code2Q <= wordC2;
      indCnt <= indCnt + 1'b1;
    end else begin
      if (ctl.doAdd) acc <= sum;
      if (ctl.push) begin
        stkCnt <= stkCnt + 1'b1;
      end else if (ctl.pop) begin
        code2Q <= stk[stkTop];
        stkCnt <= stkCnt - 1'b1;
      end
    end
  end

  // stack storage needs no reset: entries are written before they are read
  always_ff @(posedge clk) begin
    if (ctl.push) stk[stkPush] <= code2Q;
  end

  // R8: saved codes never exceed the stack depth
  a_r8_stack_bound: assert property (@(posedge clk) disable iff (!rstN)
    stkCnt <= StkCntW'(StackDepth));

  // R9: fetches never exceed the limit
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    indCnt <= CntW'(MaxIndir));

  // R4: each read strobe is followed by exactly one count step once the word lands
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issueRead |=> ##1 (indCnt == CntW'($past(indCnt, 2) + 1'b1)));

endmodule

// File: rtl/ea_control.sv
module ea_control
  import ea_resolve_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CodeW-1:0] code1,
  input  logic [CodeW-1:0] code2,
  input  logic             stkEmpty,
  input  logic             stkFull,
  input  logic             cntAtMax,
  input  logic             sumOvf,
  input  logic             wordIllegal,
  output eaStrobe_t        ctl,
  output logic             useSecond,
  output logic             done,
  output logic             errOverflow,
  output logic             errIllegal,
  output logic             errStack,
  output logic             errLimit
);

  eaState_t state, nextState;
  logic setOvf, setIll, setStk, setLim;

  assign useSecond = (state == StApply2);
  assign done      = (state == StDone);

  always_comb begin
    ctl       = '0;
    nextState = state;
    setOvf    = 1'b0;
    setIll    = 1'b0;
    setStk    = 1'b0;
    setLim    = 1'b0;
    unique case (state)
      StIdle: begin
        if (start) begin
          ctl.loadStart = 1'b1;
          nextState     = StApply1;
        end
      end
      StApply1: begin
        if (code1 != CodeIndirect) begin
          ctl.doAdd = 1'b1;
          if (sumOvf) begin
            setOvf    = 1'b1;
            nextState = StDone;
          end else begin
            nextState = StApply2;
          end
        end else if ((code2 != '0) && stkFull) begin
          setStk    = 1'b1;
          nextState = StDone;
        end else if (cntAtMax) begin
          setLim    = 1'b1;
          nextState = StDone;
        end else begin
          ctl.push      = (code2 != '0);
          ctl.issueRead = 1'b1;
          nextState     = StWait;
        end
      end
      StApply2: begin
        if (code2 != CodeIndirect) begin
          ctl.doAdd = 1'b1;
          if (sumOvf) begin
            setOvf    = 1'b1;
            nextState = StDone;
          end else if (!stkEmpty) begin
            ctl.pop = 1'b1;
          end else begin
            nextState = StDone;
          end
        end else if (cntAtMax) begin
          setLim    = 1'b1;
          nextState = StDone;
        end else begin
          ctl.issueRead = 1'b1;
          nextState     = StWait;
        end
      end
      StWait: begin
        ctl.takeWord = 1'b1;
        if (wordIllegal) begin
          setIll    = 1'b1;
          nextState = StDone;
        end else begin
          nextState = StApply1;
        end
      end
      StDone:  nextState = StIdle;
      default: nextState = StIdle;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= StIdle;
      errOverflow <= 1'b0;
      errIllegal  <= 1'b0;
      errStack    <= 1'b0;
      errLimit    <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.loadStart) begin
        errOverflow <= 1'b0;
        errIllegal  <= 1'b0;
        errStack    <= 1'b0;
        errLimit    <= 1'b0;
      end else begin
        errOverflow <= errOverflow | setOvf;
        errIllegal  <= errIllegal  | setIll;
        errStack    <= errStack    | setStk;
        errLimit    <= errLimit    | setLim;
      end
    end
  end

  // R10: completion is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: the cycle after a read is spent taking the word, never reading again
  a_r3_read_gap: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issueRead |=> !ctl.issueRead);

  // R6: an out-of-range sum ends the walk with the flag raised
  a_r6_ovf_flag: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doAdd && sumOvf) |=> (errOverflow && done));

  // R7: the illegal-word flag appears together with completion
  a_r7_illegal_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errIllegal) |-> done);

endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
  import ea_resolve_pkg::*;
#(
  parameter int ByteW      = 6,
  parameter int StackDepth = 8,
  parameter int MaxIndir   = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [2*ByteW:0]              baseAddr,
  input  logic [2*CodeW-1:0]            idxField,
  input  logic [6*(2*ByteW+1)-1:0]      idxRegs,
  output logic                          memRdEn,
  output logic [2*ByteW-1:0]            memRdAddr,
  input  logic [5*ByteW:0]              memRdData,
  output logic                          done,
  output logic [2*ByteW:0]              effAddr,
  output logic [$clog2(MaxIndir+1)-1:0] indirCount,
  output logic                          errOverflow,
  output logic                          errIllegal,
  output logic                          errStack,
  output logic                          errLimit
);

  eaStrobe_t        ctl;
  logic             useSecond;
  logic [CodeW-1:0] code1, code2;
  logic             stkEmpty, stkFull, cntAtMax, sumOvf, wordIllegal;

  assign memRdEn = ctl.issueRead;

  ea_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .code1       (code1),
    .code2       (code2),
    .stkEmpty    (stkEmpty),
    .stkFull     (stkFull),
    .cntAtMax    (cntAtMax),
    .sumOvf      (sumOvf),
    .wordIllegal (wordIllegal),
    .ctl         (ctl),
    .useSecond   (useSecond),
    .done        (done),
    .errOverflow (errOverflow),
    .errIllegal  (errIllegal),
    .errStack    (errStack),
    .errLimit    (errLimit)
  );

  ea_datapath #(
    .ByteW      (ByteW),
    .StackDepth (StackDepth),
    .MaxIndir   (MaxIndir)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .useSecond   (useSecond),
    .baseAddr    (baseAddr),
    .idxField    (idxField),
    .idxRegs     (idxRegs),
    .memRdData   (memRdData),
    .memRdAddr   (memRdAddr),
    .effAddr     (effAddr),
    .indirCount  (indirCount),
    .code1       (code1),
    .code2       (code2),
    .stkEmpty    (stkEmpty),
    .stkFull     (stkFull),
    .cntAtMax    (cntAtMax),
    .sumOvf      (sumOvf),
    .wordIllegal (wordIllegal)
  );

endmodule

// File: tb/ea_resolver_bench.sv
`timescale 1ns/1ps
module ea_resolver_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [12:0] baseAddr = '0;
  logic [5:0]  idxField = '0;
  logic [77:0] idxRegs = '0;
  logic        memRdEn;
  logic [11:0] memRdAddr;
  logic [30:0] memRdData = '0;
  logic        done;
  logic [12:0] effAddr;
  logic [6:0]  indirCount;
  logic        errOverflow, errIllegal, errStack, errLimit;

  ea_resolver u_ea_resolver (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .idxField(idxField), .idxRegs(idxRegs), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .done(done),
    .effAddr(effAddr), .indirCount(indirCount), .errOverflow(errOverflow),
    .errIllegal(errIllegal), .errStack(errStack), .errLimit(errLimit)
  );

  always #4 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  int regs [1:6];
  logic [30:0] memArr [int];
  int expReads [$];
  int eAcc, eCyc, eInd;
  bit eOvf, eIll, eStk, eLim;

  always @(posedge clk) begin
    if (memRdEn) memRdData <= memArr.exists(int'(memRdAddr)) ? memArr[int'(memRdAddr)] : '0;
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  function automatic logic [12:0] toSm(int v);
    return {(v < 0) ? 1'b1 : 1'b0, 12'((v < 0) ? -v : v)};
  endfunction

  function automatic int smToInt(logic [12:0] v);
    return v[12] ? -int'(v[11:0]) : int'(v[11:0]);
  endfunction

  function automatic logic [30:0] mkWord(int addr, int c1, int c2);
    return {toSm(addr), 3'(c1), 3'(c2), 12'h5A5};
  endfunction

  function automatic int absv(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic loadRegs();
    for (int k = 1; k <= 6; k++) idxRegs[k*13-1 -: 13] = toSm(regs[k]);
  endtask

  // behavioural reference: a queue of codes still to apply; first codes tagged with +8
  task automatic model(int base, int c1, int c2);
    int work [$];
    int acc, e, x, a;
    bit first;
    logic [30:0] w;
    acc = base;
    eCyc = 0; eInd = 0;
    eOvf = 0; eIll = 0; eStk = 0; eLim = 0;
    expReads.delete();
    work.push_back(c1 + 8);
    work.push_back(c2);
    while (work.size() > 0) begin
      e = work.pop_front();
      x = e % 8;
      first = (e >= 8);
      if (x != 7) begin
        eCyc++;
        if (x != 0) acc += regs[x];
        if (acc > 4095 || acc < -4095) begin eOvf = 1; break; end
      end else begin
        if (first) begin
          if (work[0] == 0) void'(work.pop_front());
          else if (work.size() - 1 >= 8) begin eCyc++; eStk = 1; break; end
        end
        if (eInd == 64) begin eCyc++; eLim = 1; break; end
        eCyc += 2;
        eInd++;
        a = absv(acc);
        expReads.push_back(a);
        w = memArr.exists(a) ? memArr[a] : '0;
        acc = w[30] ? -int'(w[29:18]) : int'(w[29:18]);
        if (w[17:15] == 3'd7 && w[14:12] == 3'd7) begin eIll = 1; break; end
        work.push_front(int'(w[14:12]));
        work.push_front(int'(w[17:15]) + 8);
      end
    end
    eAcc = acc;
  endtask

  task automatic runCase(string req, int base, int c1, int c2, bit intrude);
    int rd;
    bit anyErr;
    model(base, c1, c2);
    anyErr = eOvf | eIll | eStk | eLim;
    @(negedge clk);
    baseAddr = toSm(base);
    idxField = {3'(c1), 3'(c2)};
    start = 1'b1;
    for (int k = 1; k <= eCyc + 1; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (intrude && k == 2) begin start = 1'b1; baseAddr = toSm(base + 7); idxField = 6'o11; end
      if (intrude && k == 3) start = 1'b0;
      // R10: done rises exactly after the modelled cycle count
      check(done === (k == eCyc + 1), req, "done timing (R10)", int'(done), int'(k == eCyc + 1));
      if (memRdEn) begin
        rd = (expReads.size() > 0) ? expReads.pop_front() : -1;
        // R3: read address is the magnitude of the current address
        check(int'(memRdAddr) == rd, req, "read address (R3)", int'(memRdAddr), rd);
      end
    end
    check(expReads.size() == 0, req, "reads missing (R3)", expReads.size(), 0);
    if (!anyErr) check(smToInt(effAddr) == eAcc && !(effAddr == 13'h1000), req, "address", smToInt(effAddr), eAcc);
    // R4: indirection count
    check(int'(indirCount) == eInd, req, "indirections (R4)", int'(indirCount), eInd);
    check(errOverflow == eOvf, req, "overflow flag (R6)", int'(errOverflow), int'(eOvf));
    check(errIllegal == eIll, req, "illegal flag (R7)", int'(errIllegal), int'(eIll));
    check(errStack == eStk, req, "stack flag (R8)", int'(errStack), int'(eStk));
    check(errLimit == eLim, req, "limit flag (R9)", int'(errLimit), int'(eLim));
    @(negedge clk);
    // R11: result holds after completion
    check(!done, req, "done dropped (R11)", int'(done), 0);
    if (!anyErr) check(smToInt(effAddr) == eAcc, req, "held address (R11)", smToInt(effAddr), eAcc);
  endtask

  initial begin
    regs[1] = 1; regs[2] = 2; regs[3] = -30; regs[4] = -4000; regs[5] = 77; regs[6] = 4000;
    loadRegs();
    memArr[1000] = mkWord(1000, 1, 7);
    memArr[1001] = mkWord(1000, 0, 2);
    memArr[2002] = mkWord(3000, 0, 1);
    memArr[300]  = mkWord(400, 0, 0);
    memArr[400]  = mkWord(50, 1, 0);
    memArr[25]   = mkWord(-60, 5, 0);
    memArr[20]   = mkWord(0, 7, 7);
    memArr[10]   = mkWord(10, 7, 1);
    memArr[5]    = mkWord(5, 0, 7);

    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && !memRdEn, "R1", "done/read idle", int'(done) + int'(memRdEn), 0);
    check(!(errOverflow | errIllegal | errStack | errLimit), "R1", "flags clear",
          int'({errOverflow, errIllegal, errStack, errLimit}), 0);
    check(indirCount == '0, "R1", "count zero", int'(indirCount), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: plain index arithmetic, both code slots, mixed signs
    runCase("R2", 100, 0, 0, 0);
    runCase("R2", 100, 1, 3, 0);
    runCase("R2", -5, 5, 6, 0);
    runCase("R2", 30, 3, 0, 0);
    // R5: nested worked chain
    runCase("R5", 1000, 7, 2, 0);
    // R3: index then tail indirect (table of tables)
    runCase("R3", 2000, 2, 7, 0);
    // R10: pending zero after indirect costs nothing
    runCase("R10", 1001, 7, 0, 0);
    // R7: top-level 7:7 is legal
    runCase("R7", 300, 7, 7, 0);
    // R3: indirection through a negative address uses its magnitude
    runCase("R3", -25, 7, 0, 0);
    // R6: overflow, positive, negative and intermediate
    runCase("R6", 200, 6, 0, 0);
    runCase("R6", -100, 4, 0, 0);
    runCase("R6", 100, 6, 4, 0);
    // R7: illegal fetched word
    runCase("R7", 20, 0, 7, 0);
    // R8: stack exhaustion
    runCase("R8", 10, 7, 1, 0);
    // R9: runaway chain
    runCase("R9", 5, 0, 7, 0);
    // R11: start during a walk is ignored
    runCase("R11", 1000, 7, 2, 1);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule